// File: doc/BRIEF.md
# Windowed Ones-Count Decimator

This block turns the one-bit oversampled stream of a first-order delta-sigma modulator into multi-bit samples at a rate 2^OUT_W times lower. It splits the stream into windows of N = 2^OUT_W clock cycles and counts the ones that arrive in each window. When a window ends, the count moves into a holding register and a fresh count begins. The held word is the density of ones in that window, read as a binary fraction between 0 and 1. As a filter, this averages over each window and drops all but one sample per window, which gives a first-order sinc low-pass response.

A synchronous start input begins a new conversion. It clears the count, the held word and the window position. The first result is flagged N+1 cycles after start is released, and every N cycles after that. Each flag lasts one cycle.

Top module: `sinc_window_decimator`

## Requirements
- R1: On each rising edge with start low, the running count rises by one when `bit_i` is 1 and keeps its value when `bit_i` is 0.
- R2: An edge with `start_i` high clears the running count, `result_o`, `valid_o` and the window position. The stream bit on that edge is not counted.
- R3: After the first result, `valid_o` goes high for exactly one cycle once every N = 2^OUT_W cycles. N is 256 with the default OUT_W of 8.
- R4: Each result equals the number of ones in the N stream bits of its window. With 207, 180, 128 and 75 ones in a 256-bit window, the results are 207, 180, 128 and 75.
- R5: A window in which all N bits are 1 yields 2^OUT_W-1 (255 by default). It does not wrap to 0.
- R6: The bit that arrives on the edge where a result is loaded counts toward the next window. A window whose only 1 is its first bit yields 1.
- R7: `result_o` changes only on an edge where a result is loaded (it is flagged by `valid_o` in the following cycle) or on a start edge.
- R8: Let edge 1 be the first edge after the start edge. Windows are edges 1..N, N+1..2N, and so on. The first result is loaded on edge N+1. `valid_o` stays low until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| start_i | input | 1 | Synchronous start of conversion, active high |
| bit_i | input | 1 | Modulator output stream |
| result_o | output | OUT_W (8) | Ones count of the last completed window |
| valid_o | output | 1 | One-cycle flag: `result_o` has just been loaded |

## Verification
Two cases are hard to reach: a window that holds only ones, and a one that lands exactly on the load edge. Both need the stimulus to stay aligned with the internal window position, which no port shows. The bench therefore counts cycles from the release of start and drives whole windows from generated bit patterns. It uses the all-ones pattern and patterns with a single one at the first or last position of a window. A start in the middle of a window then checks that alignment restarts from the new start edge.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;
    localparam int DEF_OUT_W = 8;

    typedef enum logic {
        WIN_FIRST  = 1'b0,
        WIN_STEADY = 1'b1
    } win_state_e;
endpackage

// File: rtl/window_timer.sv
module window_timer
    import sinc_decim_pkg::*;
#(
    parameter int OUT_W = DEF_OUT_W
) (
    input  logic clk_i,
    input  logic start_i,
    output logic dump_o
);
    typedef struct packed {
        logic [OUT_W-1:0] phase;
        win_state_e       state;
    } timer_t;

    timer_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (start_i) begin
            nxt_d.phase = '0;
            nxt_d.state = WIN_FIRST;
        end else begin
            nxt_d.phase = cur_q.phase + 1'b1;
            if (&cur_q.phase) begin
                nxt_d.state = WIN_STEADY;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        cur_q <= nxt_d;
    end

    assign dump_o = (cur_q.phase == '0) && (cur_q.state == WIN_STEADY) && !start_i;
endmodule

// File: rtl/ones_counter.sv
module ones_counter
    import sinc_decim_pkg::*;
#(
    parameter int OUT_W = DEF_OUT_W
) (
    input  logic             clk_i,
    input  logic             start_i,
    input  logic             dump_i,
    input  logic             bit_i,
    output logic [OUT_W-1:0] tally_o
);
    typedef struct packed {
        logic [OUT_W-1:0] tally;
    } cnt_t;

    cnt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (start_i) begin
            nxt_d.tally = '0;
        end else if (dump_i) begin
            nxt_d.tally = {{(OUT_W-1){1'b0}}, bit_i};
        end else if (bit_i && !(&cur_q.tally)) begin
            nxt_d.tally = cur_q.tally + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        cur_q <= nxt_d;
    end

    assign tally_o = cur_q.tally;
endmodule

// File: rtl/dump_register.sv
module dump_register
    import sinc_decim_pkg::*;
#(
    parameter int OUT_W = DEF_OUT_W
) (
    input  logic             clk_i,
    input  logic             start_i,
    input  logic             dump_i,
    input  logic [OUT_W-1:0] tally_i,
    output logic [OUT_W-1:0] result_o,
    output logic             valid_o
);
    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             fresh;
    } hold_t;

    hold_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.fresh = 1'b0;
        if (start_i) begin
            nxt_d.word = '0;
        end else if (dump_i) begin
            nxt_d.word  = tally_i;
            nxt_d.fresh = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        cur_q <= nxt_d;
    end

    assign result_o = cur_q.word;
    assign valid_o  = cur_q.fresh;
endmodule

// File: rtl/sinc_window_decimator.sv
module sinc_window_decimator
    import sinc_decim_pkg::*;
#(
    parameter int OUT_W = DEF_OUT_W
) (
    input  logic             clk_i,
    input  logic             start_i,
    input  logic             bit_i,
    output logic [OUT_W-1:0] result_o,
    output logic             valid_o
);
    logic             dump;
    logic [OUT_W-1:0] tally;

    window_timer #(.OUT_W(OUT_W)) u_timer (
        .clk_i   (clk_i),
        .start_i (start_i),
        .dump_o  (dump)
    );

    ones_counter #(.OUT_W(OUT_W)) u_count (
        .clk_i   (clk_i),
        .start_i (start_i),
        .dump_i  (dump),
        .bit_i   (bit_i),
        .tally_o (tally)
    );

    dump_register #(.OUT_W(OUT_W)) u_hold (
        .clk_i    (clk_i),
        .start_i  (start_i),
        .dump_i   (dump),
        .tally_i  (tally),
        .result_o (result_o),
        .valid_o  (valid_o)
    );
endmodule

// File: rtl/sinc_window_decimator_checker.sv
module sinc_window_decimator_checker #(
    parameter int OUT_W = 8
) (
    input logic             clk_i,
    input logic             start_i,
    input logic [OUT_W-1:0] result_o,
    input logic             valid_o
);
    localparam int N     = 1 << OUT_W;
    localparam int GAP_W = OUT_W + 2;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk_i) begin
        if (start_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (valid_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (!(&gap_q)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_start_clears_R2: assert property (@(posedge clk_i)
        start_i |=> (result_o == '0) && !valid_o);

    assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (start_i)
        valid_o |=> !valid_o);

    assert_period_R3: assert property (@(posedge clk_i) disable iff (start_i)
        (valid_o && seen_q) |-> (gap_q == GAP_W'(N - 1)));

    assert_first_result_R8: assert property (@(posedge clk_i) disable iff (start_i)
        (valid_o && !seen_q) |-> (gap_q == GAP_W'(N + 1)));

    assert_hold_R7: assert property (@(posedge clk_i) disable iff (start_i)
        (!valid_o && !$past(start_i)) |-> $stable(result_o));
endmodule

bind sinc_window_decimator sinc_window_decimator_checker #(.OUT_W(OUT_W)) u_checker (
    .clk_i    (clk_i),
    .start_i  (start_i),
    .result_o (result_o),
    .valid_o  (valid_o)
);

// File: tb/tb_sinc_window_decimator.sv
`timescale 1ns/1ps
module tb_sinc_window_decimator;
    localparam int OUT_W = 8;
    localparam int N     = 1 << OUT_W;
    localparam int MAXV  = N - 1;

    logic             clk = 1'b0;
    logic             start;
    logic             sbit;
    logic [OUT_W-1:0] result;
    logic             valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural reference state
    int win_q[$];
    int ph      = 0;
    bit primed  = 0;
    int exp_out = 0;
    bit exp_v   = 0;
    int valid_seen = 0;

    always #2.5 clk = ~clk;

    sinc_window_decimator #(.OUT_W(OUT_W)) dut (
        .clk_i    (clk),
        .start_i  (start),
        .bit_i    (sbit),
        .result_o (result),
        .valid_o  (valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int win_sum();
        int s = 0;
        foreach (win_q[i]) s += win_q[i];
        return (s > MAXV) ? MAXV : s;
    endfunction

    task automatic model_edge(input bit b, input bit st);
        if (st) begin
            win_q.delete();
            ph = 0; primed = 0; exp_out = 0; exp_v = 0;
        end else begin
            exp_v = (ph == 0) && primed;
            if (exp_v) begin
                exp_out = win_sum();
                win_q.delete();
            end
            win_q.push_back(b);
            if (ph == N - 1) primed = 1;
            ph = (ph + 1) % N;
        end
    endtask

    task automatic step(input bit b, input bit st);
        @(negedge clk);
        sbit  = b;
        start = st;
        @(posedge clk);
        #1;
        model_edge(b, st);
        if (valid) valid_seen++;
        check(result == exp_out[OUT_W-1:0], "R7/R4 result", int'(result), exp_out);
        check(valid == exp_v, "R3 valid", int'(valid), int'(exp_v));
    endtask

    function automatic bit pat(input int k, input int i);
        return (((i + 1) * k) / N) != ((i * k) / N);
    endfunction

    // kind: 0 density k, 1 only first bit, 2 only last bit
    task automatic run_window(input int kind, input int k);
        for (int i = 0; i < N; i++) begin
            bit b;
            if (kind == 0)      b = pat(k, i);
            else if (kind == 1) b = (i == 0);
            else                b = (i == N - 1);
            step(b, 1'b0);
        end
    endtask

    task automatic check_dump(input string req, input int expv);
        step(1'b0, 1'b0);
        check(valid == 1'b1, {req, " dump flag"}, int'(valid), 1);
        check(int'(result) == expv, req, int'(result), expv);
    endtask

    initial begin
        start = 1'b1;
        sbit  = 1'b0;
        model_edge(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
        check(result == '0, "R2 reset result", int'(result), 0);
        check(valid == 1'b0, "R2 reset valid", int'(valid), 0);

        // R8: first window, no flag before the first full window
        valid_seen = 0;
        run_window(0, 207);
        check(valid_seen == 0, "R8 no early valid", valid_seen, 0);
        // R4 worked densities; R1 counting
        start = 1'b0;
        step(pat(180, 0), 1'b0);
        check(int'(result) == 207, "R4 207 ones", int'(result), 207);
        for (int i = 1; i < N; i++) step(pat(180, i), 1'b0);
        step(pat(128, 0), 1'b0);
        check(int'(result) == 180, "R4 180 ones", int'(result), 180);
        for (int i = 1; i < N; i++) step(pat(128, i), 1'b0);
        step(pat(75, 0), 1'b0);
        check(int'(result) == 128, "R4 128 ones", int'(result), 128);
        for (int i = 1; i < N; i++) step(pat(75, i), 1'b0);
        step(1'b1, 1'b0);
        check(int'(result) == 75, "R4 75 ones", int'(result), 75);
        // R5: all ones (first bit already driven above)
        for (int i = 1; i < N; i++) step(1'b1, 1'b0);
        check_dump("R5 saturate", MAXV);
        // zero window (R1 hold on zeros)
        for (int i = 1; i < N; i++) step(1'b0, 1'b0);
        check_dump("R1 all zeros", 0);
        // R6: lone one on the dump edge of the next window
        for (int i = 1; i < N; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        check(valid == 1'b1, "R6 dump edge flag", int'(valid), 1);
        check(int'(result) == 0, "R6 prior window", int'(result), 0);
        for (int i = 1; i < N; i++) step(1'b0, 1'b0);
        check_dump("R6 dump-edge bit counted", 1);
        // lone one on the last bit
        for (int i = 1; i < N - 1; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        check_dump("R6 last bit", 1);
        // R2: start in mid window
        for (int i = 0; i < 100; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check(result == '0, "R2 mid start result", int'(result), 0);
        check(valid == 1'b0, "R2 mid start valid", int'(valid), 0);
        valid_seen = 0;
        run_window(0, 50);
        check(valid_seen == 0, "R8 no early valid after restart", valid_seen, 0);
        check_dump("R8 first window after restart", 50);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        check(int'(result) == 50, "R7 hold between dumps", int'(result), 50);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule